// File: doc/BRIEF.md
# Addressing Mode Address Generator

This block forms the operand effective address for one operand specifier per cycle. It also forms the new value of the base register for the two modes that modify that register. Each accepted request carries an addressing mode, the base register contents, the index register contents, the program counter, a displacement, a flag that says whether the displacement is a full word or a sign-extended byte, a two-bit scale code and an element size. One cycle later the block presents the effective address, the register write-back value and its enable, and a flag that tells the memory stage whether an operand access is needed.

The register file, the memory port and instruction decode are outside the block. Decode supplies the register values and the mode. The pipeline routes the write-back to the base register and uses the memory flag to decide whether to start an access. All arithmetic wraps modulo 2^32.

Top module: `agu_top`

## Requirements
- R1: While `rst` is high and on the first output cycle after it, `out_valid`, `wb_en` and `mem_access` are low.
- R2: `out_valid` equals the `in_valid` of the previous cycle. While `out_valid` is low, `wb_en` and `mem_access` are low.
- R3: Mode 0 (register indirect): the effective address is `base_val`.
- R4: Mode 1 (post-increment): the effective address is the old `base_val`, and `wb_value` is `base_val + step`, wrapping modulo 2^32.
- R5: Mode 2 (pre-decrement): `wb_value` is `base_val - step`, wrapping modulo 2^32, and the effective address equals that decremented value.
- R6: Mode 3 (indexed): the effective address is `base_val` plus the displacement.
- R7: Mode 4 (PC-relative): the effective address is `pc_val` plus the displacement.
- R8: Mode 5 (scaled index): the effective address is `base_val + (index_val << scale) + displacement`, where `scale` 0..3 selects a multiplier of 1, 2, 4 or 8.
- R9: With `disp_wide` = 1 the displacement is all 32 bits of `disp`. With `disp_wide` = 0 it is `disp[7:0]` sign-extended, and `disp[31:8]` has no effect.
- R10: Mode 6 (immediate) and mode 7 (register direct) give `mem_access` low and `wb_en` low.
- R11: `wb_en` is high only for modes 1 and 2. `mem_access` is high for every valid request in modes 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code 0..7 |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| pc_val | input | 32 | Program counter |
| disp | input | 32 | Displacement |
| disp_wide | input | 1 | 1: full-word displacement, 0: sign-extended low byte |
| scale | input | 2 | Index shift amount 0..3 |
| step | input | 3 | Element size 1, 2 or 4 |
| out_valid | output | 1 | Result present |
| eff_addr | output | 32 | Effective address |
| wb_value | output | 32 | New base register value |
| wb_en | output | 1 | Write `wb_value` back to the base register |
| mem_access | output | 1 | Operand requires a memory access |

## Verification
Every result is registered once, so an error in mode decode, in the choice of adder operands or in displacement extension shows at the ports exactly one cycle after the offending request. It appears as a wrong `eff_addr`, a spurious or missing `wb_en`, or a wrong `mem_access`. The order of post-increment and pre-decrement is the subtle part. If that order is swapped, `eff_addr` differs from the base value by `step` while `wb_value` can still look plausible, so the address and the write-back are compared separately. Wrap-around at both ends of the address space shows a carry or borrow fault in the same cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int ADDR_W   = 32;
    localparam int NARROW_W = 8;
    localparam int SCALE_W  = 2;
    localparam int STEP_W   = 3;
    localparam int MODE_W   = 3;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [MODE_W-1:0] {
        AM_REG_IND  = 3'd0,
        AM_POST_INC = 3'd1,
        AM_PRE_DEC  = 3'd2,
        AM_INDEXED  = 3'd3,
        AM_PC_REL   = 3'd4,
        AM_SCALED   = 3'd5,
        AM_IMM      = 3'd6,
        AM_REG_DIR  = 3'd7
    } amode_e;

    typedef struct packed {
        amode_e              mode;
        addr_t               base;
        addr_t               index;
        addr_t               pc;
        addr_t               disp;
        logic                disp_wide;
        logic [SCALE_W-1:0]  scale;
        logic [STEP_W-1:0]   step;
    } agu_req_t;

    typedef struct packed {
        addr_t ea;
        addr_t wb;
        logic  wb_en;
        logic  mem;
    } agu_rsp_t;

    function automatic logic mode_writes_back(amode_e m);
        return (m == AM_POST_INC) || (m == AM_PRE_DEC);
    endfunction

    function automatic logic mode_needs_mem(amode_e m);
        return !((m == AM_IMM) || (m == AM_REG_DIR));
    endfunction

endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 8
) (
    input  logic [ADDR_W-1:0] disp_in,
    input  logic              wide,
    output logic [ADDR_W-1:0] disp_out
);
    localparam int PAD_W = ADDR_W - NARROW_W;

    logic [ADDR_W-1:0] narrow_ext;

    // The sign bit of the short field fills every upper bit.
    assign narrow_ext = {{PAD_W{disp_in[NARROW_W-1]}}, disp_in[NARROW_W-1:0]};
    assign disp_out   = wide ? disp_in : narrow_ext;

endmodule

// File: rtl/agu_index_scaler.sv
module agu_index_scaler #(
    parameter int ADDR_W  = 32,
    parameter int SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  index_in,
    input  logic [SCALE_W-1:0] scale,
    output logic [ADDR_W-1:0]  scaled_out
);
    localparam int N_SHIFT = 1 << SCALE_W;

    logic [ADDR_W-1:0] cand [N_SHIFT];

    // One fixed shift per scale code; the code then picks one of them.
    for (genvar g = 0; g < N_SHIFT; g++) begin : g_shift
        assign cand[g] = index_in << g;
    end

    assign scaled_out = cand[scale];

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
(
    input  agu_req_t req,
    output agu_rsp_t rsp
);
    localparam int STEP_PAD = ADDR_W - STEP_W;

    addr_t disp_x;
    addr_t scaled_idx;
    addr_t step_x;

    agu_disp_ext #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) u_disp (
        .disp_in  (req.disp),
        .wide     (req.disp_wide),
        .disp_out (disp_x)
    );

    agu_index_scaler #(
        .ADDR_W  (ADDR_W),
        .SCALE_W (SCALE_W)
    ) u_scale (
        .index_in   (req.index),
        .scale      (req.scale),
        .scaled_out (scaled_idx)
    );

    assign step_x = {{STEP_PAD{1'b0}}, req.step};

    always_comb begin
        rsp.ea    = req.base;
        rsp.wb    = req.base;
        rsp.wb_en = mode_writes_back(req.mode);
        rsp.mem   = mode_needs_mem(req.mode);
        case (req.mode)
            AM_REG_IND: begin
                rsp.ea = req.base;
            end
            AM_POST_INC: begin
                // Access at the old value; the register moves afterwards.
                rsp.ea = req.base;
                rsp.wb = req.base + step_x;
            end
            AM_PRE_DEC: begin
                // The register moves first; the access uses the new value.
                rsp.wb = req.base - step_x;
                rsp.ea = req.base - step_x;
            end
            AM_INDEXED: begin
                rsp.ea = req.base + disp_x;
            end
            AM_PC_REL: begin
                rsp.ea = req.pc + disp_x;
            end
            AM_SCALED: begin
                rsp.ea = req.base + scaled_idx + disp_x;
            end
            default: begin
                rsp.ea = req.base;
            end
        endcase
    end

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [MODE_W-1:0]   mode,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [ADDR_W-1:0]   index_val,
    input  logic [ADDR_W-1:0]   pc_val,
    input  logic [ADDR_W-1:0]   disp,
    input  logic                disp_wide,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [STEP_W-1:0]   step,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic [ADDR_W-1:0]   wb_value,
    output logic                wb_en,
    output logic                mem_access
);
    localparam int STEP_PAD = ADDR_W - STEP_W;

    agu_req_t req;
    agu_rsp_t rsp;
    agu_rsp_t rsp_q;
    logic     valid_q;

    always_comb begin
        req.mode      = amode_e'(mode);
        req.base      = base_val;
        req.index     = index_val;
        req.pc        = pc_val;
        req.disp      = disp;
        req.disp_wide = disp_wide;
        req.scale     = scale;
        req.step      = step;
    end

    agu_addr_calc u_calc (
        .req (req),
        .rsp (rsp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q     <= in_valid;
            rsp_q.ea    <= rsp.ea;
            rsp_q.wb    <= rsp.wb;
            rsp_q.wb_en <= in_valid & rsp.wb_en;
            rsp_q.mem   <= in_valid & rsp.mem;
        end
    end

    assign out_valid  = valid_q;
    assign eff_addr   = rsp_q.ea;
    assign wb_value   = rsp_q.wb;
    assign wb_en      = rsp_q.wb_en;
    assign mem_access = rsp_q.mem;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wb_en && !mem_access));

    a_r4_post_inc_order: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == AM_POST_INC) |=>
            (eff_addr == $past(base_val) &&
             wb_value == $past(base_val) + {{STEP_PAD{1'b0}}, $past(step)}));

    a_r5_pre_dec_order: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == AM_PRE_DEC) |=>
            (eff_addr == wb_value &&
             wb_value == $past(base_val) - {{STEP_PAD{1'b0}}, $past(step)}));

    a_r10_no_mem_access: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mode == AM_IMM || mode == AM_REG_DIR)) |=>
            (!mem_access && !wb_en));

    a_r11_we_only_autoidx: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != AM_POST_INC && mode != AM_PRE_DEC) |=> !wb_en);

    a_r11_mem_for_memory_modes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode <= AM_SCALED) |=> mem_access);

endmodule

// File: tb/sim_agu_top.sv
module sim_agu_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  mode;
    logic [31:0] base_val, index_val, pc_val, disp;
    logic        disp_wide;
    logic [1:0]  scale;
    logic [2:0]  step;
    logic        out_valid;
    logic [31:0] eff_addr, wb_value;
    logic        wb_en, mem_access;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    agu_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .base_val(base_val), .index_val(index_val), .pc_val(pc_val),
        .disp(disp), .disp_wide(disp_wide), .scale(scale), .step(step),
        .out_valid(out_valid), .eff_addr(eff_addr), .wb_value(wb_value),
        .wb_en(wb_en), .mem_access(mem_access)
    );

    localparam int NV = 14;
    localparam logic [2:0]  V_MODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd3, 3'd4, 3'd4,
                                            3'd5, 3'd5, 3'd6, 3'd7, 3'd1, 3'd2, 3'd5};
    localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000, 32'h4000,
                                            32'h0, 32'h0, 32'h1000, 32'h1000, 32'h5555,
                                            32'h6666, 32'hFFFF_FFFF, 32'h0, 32'h100};
    localparam logic [31:0] V_IDX  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                            32'h3, 32'h5, 32'h0, 32'h0, 32'h0, 32'h0, 32'h2};
    localparam logic [31:0] V_PC   [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8000, 32'h8000,
                                            32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [31:0] V_DISP [NV] = '{32'h0, 32'h0, 32'h0, 32'h10, 32'hF0, 32'h100, 32'h80,
                                            32'h4, 32'h1_0000, 32'h0, 32'h0, 32'h0, 32'h0,
                                            32'hABCD_0002};
    localparam logic        V_WIDE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
                                            1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [1:0]  V_SCL  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
                                            2'd3, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
    localparam logic [2:0]  V_STEP [NV] = '{3'd1, 3'd4, 3'd2, 3'd1, 3'd1, 3'd1, 3'd1,
                                            3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd4, 3'd1};
    localparam logic [31:0] X_EA   [NV] = '{32'h1000, 32'h2000, 32'h2FFE, 32'h4010, 32'h3FF0,
                                            32'h8100, 32'h7F80, 32'h101C, 32'h1_100A, 32'h0,
                                            32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 32'h104};
    localparam logic [31:0] X_WB   [NV] = '{32'h0, 32'h2004, 32'h2FFE, 32'h0, 32'h0, 32'h0, 32'h0,
                                            32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFC, 32'h0};
    localparam logic        X_WE   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                            1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic        X_MEM  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                            1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam string       V_REQ  [NV] = '{"R3", "R4", "R5", "R6", "R9", "R7", "R9",
                                            "R8", "R9", "R10", "R10", "R4", "R5", "R9"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; mode = 3'd0; base_val = '0; index_val = '0; pc_val = '0;
        disp = '0; disp_wide = 1'b0; scale = '0; step = 3'd1;
    endtask

    task automatic drive(input int i);
        in_valid = 1'b1; mode = V_MODE[i]; base_val = V_BASE[i]; index_val = V_IDX[i];
        pc_val = V_PC[i]; disp = V_DISP[i]; disp_wide = V_WIDE[i];
        scale = V_SCL[i]; step = V_STEP[i];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        check("R1", {29'd0, out_valid, wb_en, mem_access}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        // R1/R2: first cycle after reset with idle input
        check("R1", {29'd0, out_valid, wb_en, mem_access}, 32'd0);

        // Table walk: drive at negedge, result registered at next posedge.
        for (int i = 0; i < NV; i++) begin
            drive(i);
            @(negedge clk);
            check("R2", {31'd0, out_valid}, 32'd1);
            check("R11", {31'd0, mem_access}, {31'd0, X_MEM[i]});
            check("R11", {31'd0, wb_en}, {31'd0, X_WE[i]});
            if (X_MEM[i]) check(V_REQ[i], eff_addr, X_EA[i]);
            if (X_WE[i])  check(V_REQ[i], wb_value, X_WB[i]);
        end

        // R2: idle after a write-back request gives no valid, no enables
        drive(1);
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        check("R2", {29'd0, out_valid, wb_en, mem_access}, 32'd0);

        // R9: upper displacement bits ignored in byte mode (indexed, negative byte)
        drive(4);
        disp = 32'h1234_56F0;
        @(negedge clk);
        check("R9", eff_addr, 32'h3FF0);

        // R8: scaled with each shift amount
        for (int s = 0; s < 4; s++) begin
            drive(7);
            scale = s[1:0];
            disp = 32'h0;
            @(negedge clk);
            check("R8", eff_addr, 32'h1000 + (32'd3 << s));
        end

        // R1: reset taken on the same edge as a valid request
        drive(2);
        rst = 1'b1;
        @(negedge clk);
        check("R1", {29'd0, out_valid, wb_en, mem_access}, 32'd0);
        rst = 1'b0;
        idle_inputs();
        @(negedge clk);
        check("R1", {29'd0, out_valid, wb_en, mem_access}, 32'd0);

        finish_run();
    end

endmodule